// File: doc/BRIEF.md
# Run-Time Partitioned SIMD Minimum

This block returns, for each SIMD lane, the smaller of two packed operands. Both operands are 32 bits wide and are built from four 8-bit segments. A 3-bit split mask decides at run time which segments are grouped into lanes. One datapath therefore serves a single 32-bit minimum, two 16-bit minimums, four 8-bit minimums and the mixed layouts in between. No separate scalar or vector units are needed.

Each segment compares its own bytes. The unit then chains these partial outcomes upward across every boundary that is joined. The most significant segment of a lane holds the lane's full unsigned verdict. That verdict is broadcast back down to every segment of the lane, and each segment passes either the first or the second operand's byte. The unit is purely combinational and has no clock or reset.

Top module: `simd_min_unit`

## Requirements
- R1: Split bit k (k = 0, 1, 2) lies between segment k (bits 8k+7..8k) and segment k+1. A value of 0 joins the two segments into one lane, and a value of 1 separates them.
- R2: With split mask 000, min_o is the unsigned 32-bit minimum of opa_i and opb_i.
- R3: With split mask 111, each byte of min_o is the unsigned minimum of the matching bytes of the operands.
- R4: With split mask 010, each 16-bit half of min_o is the unsigned minimum of the matching halves.
- R5: With split mask 001, bits 7..0 form an 8-bit lane and bits 31..8 form a 24-bit lane, and each lane returns its own minimum.
- R6: For every one of the 8 mask values, each lane of min_o equals the first operand's slice when that slice is less than the second operand's slice, and the second operand's slice otherwise.
- R7: Comparison is unsigned, so a slice with its top bit set is larger than any slice with that bit clear.
- R8: All segments of a lane take their bytes from the same operand. Bytes from the two operands are never mixed within one lane.
- R9: When the upper segments of a lane are equal, the verdict comes from the highest segment below them that differs. This holds down to the least significant segment of the lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand, four packed byte segments |
| opb_i | input | 32 | Second operand, same layout |
| split_i | input | 3 | Split mask, one bit per internal segment boundary |
| min_o | output | 32 | Per-lane unsigned minimum |

## Verification
The embedded checks assume that all three inputs hold settled, known values whenever the combinational logic is evaluated. They also assume that the mask and both operands change together as one input vector. The bench meets this by driving all inputs at once on the falling clock edge and sampling one time unit later. It then walks every mask value with random operand pairs, many of which share their upper bytes so that the carry of the verdict across joined boundaries is exercised.

// File: rtl/simd_min_pkg.sv
package simd_min_pkg;
    localparam int SEG_W   = 8;
    localparam int NUM_SEG = 4;
    localparam int DATA_W  = SEG_W * NUM_SEG;
    localparam int SPLIT_W = NUM_SEG - 1;
endpackage

// File: rtl/simd_seg_cmp.sv
module simd_seg_cmp #(
    parameter int SEG_W   = simd_min_pkg::SEG_W,
    parameter int NUM_SEG = simd_min_pkg::NUM_SEG,
    localparam int DATA_W = SEG_W * NUM_SEG
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    output logic [NUM_SEG-1:0] lt_o,
    output logic [NUM_SEG-1:0] eq_o
);
    // one unsigned magnitude comparator per segment
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [SEG_W-1:0] a_seg, b_seg;
        assign a_seg   = a_i[s*SEG_W +: SEG_W];
        assign b_seg   = b_i[s*SEG_W +: SEG_W];
        assign lt_o[s] = a_seg < b_seg;
        assign eq_o[s] = a_seg == b_seg;
    end
endmodule

// File: rtl/simd_lane_chain.sv
module simd_lane_chain #(
    parameter int NUM_SEG = simd_min_pkg::NUM_SEG,
    localparam int SPLIT_W = NUM_SEG - 1
) (
    input  logic [NUM_SEG-1:0] lt_i,
    input  logic [NUM_SEG-1:0] eq_i,
    input  logic [SPLIT_W-1:0] split_i,
    output logic [NUM_SEG-1:0] pick_a_o
);
    logic [NUM_SEG-1:0] lt_chain_d;

    always_comb begin
        // upward pass: carry the lower verdict across joined boundaries
        lt_chain_d[0] = lt_i[0];
        for (int s = 1; s < NUM_SEG; s++) begin
            lt_chain_d[s] = lt_i[s] |
                            (eq_i[s] & ~split_i[s-1] & lt_chain_d[s-1]);
        end
        // downward pass: broadcast each lane-top verdict to its segments
        pick_a_o[NUM_SEG-1] = lt_chain_d[NUM_SEG-1];
        for (int s = NUM_SEG - 2; s >= 0; s--) begin
            pick_a_o[s] = split_i[s] ? lt_chain_d[s] : pick_a_o[s+1];
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SEG; s++) begin
            // R9: a lane-top segment that is strictly greater never picks a
            if (s == NUM_SEG - 1 || split_i[s]) begin
                greater_top_chk: assert (lt_i[s] || eq_i[s] || !pick_a_o[s])
                    else $error("lane top picked larger operand");
            end
        end
    end
endmodule

// File: rtl/simd_seg_select.sv
module simd_seg_select #(
    parameter int SEG_W   = simd_min_pkg::SEG_W,
    parameter int NUM_SEG = simd_min_pkg::NUM_SEG,
    localparam int DATA_W = SEG_W * NUM_SEG
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [NUM_SEG-1:0] pick_a_i,
    output logic [DATA_W-1:0]  res_o
);
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_mux
        assign res_o[s*SEG_W +: SEG_W] = pick_a_i[s] ? a_i[s*SEG_W +: SEG_W]
                                                     : b_i[s*SEG_W +: SEG_W];
    end
endmodule

// File: rtl/simd_min_unit.sv
module simd_min_unit (
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic [2:0]  split_i,
    output logic [31:0] min_o
);
    import simd_min_pkg::*;

    logic [NUM_SEG-1:0] seg_lt, seg_eq, pick_a;

    simd_seg_cmp #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_cmp (
        .a_i  (opa_i),
        .b_i  (opb_i),
        .lt_o (seg_lt),
        .eq_o (seg_eq)
    );

    simd_lane_chain #(.NUM_SEG(NUM_SEG)) u_chain (
        .lt_i     (seg_lt),
        .eq_i     (seg_eq),
        .split_i  (split_i),
        .pick_a_o (pick_a)
    );

    simd_seg_select #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_sel (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .pick_a_i (pick_a),
        .res_o    (min_o)
    );

    always_comb begin
        // R2
        if (split_i == '0) begin
            full_width_min_chk: assert (min_o == ((opa_i < opb_i) ? opa_i : opb_i))
                else $error("single lane minimum wrong");
        end
        // R3
        if (split_i == '1) begin
            for (int s = 0; s < NUM_SEG; s++) begin
                byte_lane_min_chk: assert (min_o[s*SEG_W +: SEG_W] <= opa_i[s*SEG_W +: SEG_W]
                                        && min_o[s*SEG_W +: SEG_W] <= opb_i[s*SEG_W +: SEG_W])
                    else $error("byte lane exceeds an operand");
            end
        end
        // R8
        for (int s = 0; s < NUM_SEG - 1; s++) begin
            if (!split_i[s] && min_o[(s+1)*SEG_W +: SEG_W] != opb_i[(s+1)*SEG_W +: SEG_W]) begin
                joined_source_chk: assert (min_o[s*SEG_W +: SEG_W] == opa_i[s*SEG_W +: SEG_W])
                    else $error("lane mixes operand bytes");
            end
        end
        // R6
        for (int s = 0; s < NUM_SEG; s++) begin
            seg_origin_chk: assert (min_o[s*SEG_W +: SEG_W] == opa_i[s*SEG_W +: SEG_W]
                                 || min_o[s*SEG_W +: SEG_W] == opb_i[s*SEG_W +: SEG_W])
                else $error("segment from neither operand");
        end
    end
endmodule

// File: tb/simd_min_unit_test.sv
module simd_min_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa, opb, res;
    logic [2:0]  split;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    simd_min_unit uut (
        .opa_i   (opa),
        .opb_i   (opb),
        .split_i (split),
        .min_o   (res)
    );

    // fields: opa, opb, split, expected
    localparam int NVEC = 11;
    localparam logic [98:0] VECS [0:NVEC-1] = '{
        {32'h12345678, 32'h12345679, 3'b000, 32'h12345678},
        {32'h80000000, 32'h7FFFFFFF, 3'b000, 32'h7FFFFFFF},
        {32'h01FF8000, 32'h02007FFF, 3'b111, 32'h01007F00},
        {32'h00FF0100, 32'h010000FF, 3'b010, 32'h00FF00FF},
        {32'h00000005, 32'h00000103, 3'b001, 32'h00000003},
        {32'h00000005, 32'h00000103, 3'b000, 32'h00000005},
        {32'hFF000001, 32'h01000002, 3'b100, 32'h01000001},
        {32'h10203040, 32'h20103050, 3'b101, 32'h10103040},
        {32'h12345678, 32'h12335699, 3'b011, 32'h12335678},
        {32'hFF00AB00, 32'h00FFAAFF, 3'b110, 32'h0000AAFF},
        {32'h55000001, 32'h55000002, 3'b000, 32'h55000001}
    };

    function automatic logic [31:0] ref_min(input logic [31:0] a, input logic [31:0] b,
                                            input logic [2:0] m);
        logic [31:0] r = '0;
        int lo = 0;
        for (int s = 0; s < 4; s++) begin
            if (s == 3 || m[s]) begin
                logic [31:0] msk = ((s - lo) == 3) ? 32'hFFFFFFFF
                                   : ((32'h1 << (8 * (s - lo + 1))) - 32'h1);
                logic [31:0] as = (a >> (8 * lo)) & msk;
                logic [31:0] bs = (b >> (8 * lo)) & msk;
                r |= ((as < bs) ? as : bs) << (8 * lo);
                lo = s + 1;
            end
        end
        return r;
    endfunction

    task automatic apply_check(input string req, input logic [31:0] a,
                               input logic [31:0] b, input logic [2:0] m,
                               input logic [31:0] exp);
        @(negedge clk);
        opa = a; opb = b; split = m;
        #1;
        checks++;
        if (res !== exp) begin
            failures++;
            $display("FAIL %s split=%b a=%h b=%h got=%h exp=%h", req, m, a, b, res, exp);
        end
    endtask

    initial begin
        opa = '0; opb = '0; split = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: zero inputs give zero output
        apply_check("R2 reset", 32'h0, 32'h0, 3'b000, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            apply_check("R6 table", VECS[i][98:67], VECS[i][66:35],
                        VECS[i][34:32], VECS[i][31:0]);
        end

        // directed
        apply_check("R1 split bit2 only", 32'hFF000001, 32'h01000002, 3'b100, 32'h01000001);
        apply_check("R1 joined all", 32'h01FF0000, 32'h02000000, 3'b000, 32'h01FF0000);
        apply_check("R2 wide", 32'h80000000, 32'h7FFFFFFF, 3'b000, 32'h7FFFFFFF);
        apply_check("R3 bytes", 32'h01FF8000, 32'h02007FFF, 3'b111, 32'h01007F00);
        apply_check("R4 halves", 32'h00FF0100, 32'h010000FF, 3'b010, 32'h00FF00FF);
        apply_check("R5 24+8", 32'h00000005, 32'h00000103, 3'b001, 32'h00000003);
        apply_check("R7 unsigned", 32'h80808080, 32'h7F7F7F7F, 3'b111, 32'h7F7F7F7F);
        apply_check("R8 no mixing", 32'h00FF00FF, 32'h01000100, 3'b010, 32'h00FF00FF);
        apply_check("R9 low byte decides", 32'h55000001, 32'h55000002, 3'b000, 32'h55000001);
        apply_check("R9 equal lanes", 32'hABCDEF01, 32'hABCDEF01, 3'b000, 32'hABCDEF01);

        // every mask with random and shared-prefix operands
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 200; k++) begin
                logic [31:0] a = $urandom;
                logic [31:0] b = $urandom;
                if (k % 2 == 1) b = (a & (32'hFFFFFFFF << (8 * (k % 4)))) | (b >> (32 - 8 * (k % 4)));
                apply_check("R6 sweep", a, b, m[2:0], ref_min(a, b, m[2:0]));
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule